// File: doc/BRIEF.md
# Non-Posted Request Credit Gate

This block stands between a source of non-posted requests and a requester request interface that can accept up to two requests in one clock (straddled). Before each request leaves, the gate checks that enough header credit, data credit and free tags remain. Three 4-bit counts describe what remains. Each count saturates at 15, and 0 means nothing is left. These counts report issued traffic only after a fixed lag. A request sent in cycle c is first reflected in the count seen in cycle c+3. The gate therefore keeps a two-cycle record of what it has granted itself. It deducts that record, saturating at zero, before it compares a request's needs.

Each lane carries a valid/ready handshake with a header-credit need, a tag need and a payload length in Dwords. The gate converts the length into a data-credit need, at four Dwords per credit, rounded up. A lane that cannot be served sees ready low and keeps its request. The second lane is only served in a cycle in which the first lane is served, and it is judged against what the first lane leaves over. A grant output per lane marks the cycles in which a request actually leaves.

Top module: `np_credit_gate`

## Requirements
- R1: While rst_n is low, and until the first rising clock edge after rst_n goes high, grant_o and req_ready_o are all zero; reset clears the consumption history.
- R2: When the reported header-credit count or the reported data-credit count is 0, no lane is granted, even a request that needs no data credit.
- R3: A lane is granted only if each of its header, data and tag needs is at most the reported count minus the matching consumption of grants from the previous two cycles, with the difference taken as zero when negative.
- R4: Consumption granted two cycles ago is still deducted; consumption granted three or more cycles ago is not deducted.
- R5: The data-credit need of a lane is its payload length in Dwords divided by 4, rounded up (0 Dwords needs 0, 1 to 4 need 1, 17 needs 5, 61 needs 16).
- R6: Lane 1 is granted only in a cycle where lane 0 is granted, and lane 1 is judged against the availability left after lane 0's needs are deducted.
- R7: A lane whose needs do not fit holds ready low and is not granted; grant_o equals req_valid_i AND req_ready_o, so an unserved request stays presented until it fits.
- R8: A reported count of 15 is taken as exactly 15: a need of 15 fits and a need of 16 does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_avail_i | input | CNT_W (4) | Reported non-posted header credits, lagged |
| dat_avail_i | input | CNT_W (4) | Reported non-posted data credits, lagged |
| tag_avail_i | input | CNT_W (4) | Reported free tags, lagged |
| req_valid_i | input | LANES (2) | Request present, per lane |
| req_ready_o | output | LANES (2) | Lane may be issued this cycle |
| req_hdr_need_i | input | LANES x NEED_W (2x2) | Header credits needed, per lane |
| req_tag_need_i | input | LANES x NEED_W (2x2) | Tags needed, per lane |
| req_len_i | input | LANES x LEN_W (2x6) | Payload length in Dwords, per lane |
| grant_o | output | LANES (2) | Request issued this cycle, per lane |

## Verification
Deduction of the two-cycle history and the straddled second lane's judgement against what lane 0 leaves over both act on the same budget in the same cycle. The vector table provokes this by presenting a two-lane request while recent grants are still in the history. In one such cycle lane 0 drains the data budget to exactly zero, and lane 1 is then granted only if it needs no data credit. Each expected grant pair is worked out by hand from the reported counts and the needs granted in the two previous rows. A lane-0 grant paired with a lane-1 refusal shows that the combined deduction was applied, and a pair differing in either bit shows that one of the two paths went wrong.

// File: rtl/np_gate_pkg.sv
package np_gate_pkg;
   localparam int ACC_W = 8;
   typedef logic [ACC_W-1:0] acc_t;

   typedef struct packed {
      acc_t hdr;
      acc_t dat;
      acc_t tag;
   } use_t;

   function automatic acc_t sat_sub(input acc_t a, input acc_t b);
      return (a > b) ? acc_t'(a - b) : '0;
   endfunction

   function automatic use_t use_add(input use_t a, input use_t b);
      use_t r;
      r.hdr = a.hdr + b.hdr;
      r.dat = a.dat + b.dat;
      r.tag = a.tag + b.tag;
      return r;
   endfunction
endpackage

// File: rtl/np_dcred_calc.sv
module np_dcred_calc #(
   parameter int LEN_W  = 6,
   parameter int DW_PER = 4,
   parameter int DN_W   = 5
) (
   input  logic [LEN_W-1:0] len_i,
   output logic [DN_W-1:0]  need_o
);
   localparam int SHIFT = $clog2(DW_PER);
   localparam int SW    = LEN_W + SHIFT + 1;

   logic [SW-1:0] padded;
   assign padded = SW'(len_i) + SW'(DW_PER - 1);

   generate
      if ((DW_PER & (DW_PER - 1)) == 0) begin : g_pow2
         assign need_o = DN_W'(padded >> SHIFT);
      end else begin : g_div
         assign need_o = DN_W'(padded / SW'(DW_PER));
      end
   endgenerate
endmodule

// File: rtl/np_use_hist.sv
module np_use_hist
   import np_gate_pkg::*;
#(
   parameter int LAG = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  use_t now_i,
   output use_t sum_o
);
   use_t stg [LAG];

   generate
      for (genvar k = 0; k < LAG; k++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               stg[k] <= '0;
            else if (k == 0)
               stg[k] <= now_i;
            else
               stg[k] <= stg[(k == 0) ? 0 : k-1];
         end
      end
   endgenerate

   always_comb begin
      sum_o = '0;
      for (int k = 0; k < LAG; k++)
         sum_o = use_add(sum_o, stg[k]);
   end
endmodule

// File: rtl/np_lane_fit.sv
module np_lane_fit
   import np_gate_pkg::*;
(
   input  use_t avail_i,
   input  use_t used_i,
   input  use_t need_i,
   output logic fit_o
);
   use_t left;

   assign left.hdr = sat_sub(avail_i.hdr, used_i.hdr);
   assign left.dat = sat_sub(avail_i.dat, used_i.dat);
   assign left.tag = sat_sub(avail_i.tag, used_i.tag);

   assign fit_o = (need_i.hdr <= left.hdr) &&
                  (need_i.dat <= left.dat) &&
                  (need_i.tag <= left.tag);
endmodule

// File: rtl/np_credit_gate.sv
module np_credit_gate
   import np_gate_pkg::*;
#(
   parameter int CNT_W  = 4,
   parameter int LANES  = 2,
   parameter int NEED_W = 2,
   parameter int LEN_W  = 6,
   parameter int DW_PER = 4,
   parameter int LAG    = 2
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [CNT_W-1:0]              hdr_avail_i,
   input  logic [CNT_W-1:0]              dat_avail_i,
   input  logic [CNT_W-1:0]              tag_avail_i,
   input  logic [LANES-1:0]              req_valid_i,
   output logic [LANES-1:0]              req_ready_o,
   input  logic [LANES-1:0][NEED_W-1:0]  req_hdr_need_i,
   input  logic [LANES-1:0][NEED_W-1:0]  req_tag_need_i,
   input  logic [LANES-1:0][LEN_W-1:0]   req_len_i,
   output logic [LANES-1:0]              grant_o
);
   localparam int DN_W    = LEN_W - $clog2(DW_PER) + 1;
   localparam int MAX_USE = (LAG + 1) * LANES * (2 ** DN_W);

   generate
      if (MAX_USE >= 2 ** ACC_W) begin : g_bad_acc
         $error("np_credit_gate: accumulator too narrow for LAG/LANES/LEN_W");
      end
      if (CNT_W > ACC_W || NEED_W > ACC_W) begin : g_bad_w
         $error("np_credit_gate: count or need wider than accumulator");
      end
      if (LANES < 1 || LAG < 1 || DW_PER < 1) begin : g_bad_n
         $error("np_credit_gate: LANES, LAG and DW_PER must be positive");
      end
   endgenerate

   logic armed;
   logic zero_blk;
   use_t avail_w;
   use_t hist_sum;
   use_t need [LANES];
   use_t iss  [LANES+1];
   logic [LANES-1:0] fit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assign zero_blk    = (hdr_avail_i == '0) || (dat_avail_i == '0);
   assign avail_w.hdr = ACC_W'(hdr_avail_i);
   assign avail_w.dat = ACC_W'(dat_avail_i);
   assign avail_w.tag = ACC_W'(tag_avail_i);
   assign iss[0]      = '0;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         logic [DN_W-1:0] dneed;

         np_dcred_calc #(.LEN_W(LEN_W), .DW_PER(DW_PER), .DN_W(DN_W)) u_dcred (
            .len_i  (req_len_i[i]),
            .need_o (dneed)
         );

         assign need[i].hdr = ACC_W'(req_hdr_need_i[i]);
         assign need[i].dat = ACC_W'(dneed);
         assign need[i].tag = ACC_W'(req_tag_need_i[i]);

         np_lane_fit u_fit (
            .avail_i (avail_w),
            .used_i  (use_add(hist_sum, iss[i])),
            .need_i  (need[i]),
            .fit_o   (fit[i])
         );

         if (i == 0) begin : g_head
            assign req_ready_o[i] = armed & ~zero_blk & fit[i];
         end else begin : g_tail
            assign req_ready_o[i] = armed & ~zero_blk & fit[i] & grant_o[i-1];
         end

         assign grant_o[i] = req_valid_i[i] & req_ready_o[i];
         assign iss[i+1]   = grant_o[i] ? use_add(iss[i], need[i]) : iss[i];
      end
   endgenerate

   np_use_hist #(.LAG(LAG)) u_hist (
      .clk   (clk),
      .rst_n (rst_n),
      .now_i (iss[LANES]),
      .sum_o (hist_sum)
   );
endmodule

// File: rtl/np_credit_gate_chk.sv
module np_credit_gate_chk #(
   parameter int CNT_W  = 4,
   parameter int LANES  = 2,
   parameter int NEED_W = 2
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic [CNT_W-1:0]             hdr_avail_i,
   input logic [CNT_W-1:0]             dat_avail_i,
   input logic [CNT_W-1:0]             tag_avail_i,
   input logic [LANES-1:0]             req_valid_i,
   input logic [LANES-1:0]             req_ready_o,
   input logic [LANES-1:0][NEED_W-1:0] req_hdr_need_i,
   input logic [LANES-1:0][NEED_W-1:0] req_tag_need_i,
   input logic [LANES-1:0]             grant_o
);
   // R1: nothing leaves while reset is applied
   always @(posedge clk) begin
      if (!rst_n)
         a_r1_quiet_in_reset: assert (grant_o == '0 && req_ready_o == '0)
            else $error("grant or ready during reset");
   end

   a_r2_zero_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (hdr_avail_i == '0 || dat_avail_i == '0) |-> grant_o == '0);

   a_r3_hdr_bound: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[0] |-> (CNT_W'(req_hdr_need_i[0]) <= hdr_avail_i));

   a_r3_tag_bound: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[0] |-> (CNT_W'(req_tag_need_i[0]) <= tag_avail_i));

   a_r4_recent_deducted: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant_o[0]) && (CNT_W'($past(req_hdr_need_i[0])) >= hdr_avail_i))
      |-> (!grant_o[0] || req_hdr_need_i[0] == '0));

   // R6: granted lanes form a run starting at lane 0
   a_r6_in_order: assert property (@(posedge clk) disable iff (!rst_n)
      ((grant_o + 1'b1) & grant_o) == '0);

   a_r7_grant_handshake: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o == (req_valid_i & req_ready_o));
endmodule

bind np_credit_gate np_credit_gate_chk #(
   .CNT_W(CNT_W), .LANES(LANES), .NEED_W(NEED_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .hdr_avail_i    (hdr_avail_i),
   .dat_avail_i    (dat_avail_i),
   .tag_avail_i    (tag_avail_i),
   .req_valid_i    (req_valid_i),
   .req_ready_o    (req_ready_o),
   .req_hdr_need_i (req_hdr_need_i),
   .req_tag_need_i (req_tag_need_i),
   .grant_o        (grant_o)
);

// File: tb/np_credit_gate_test.sv
`timescale 1ns/1ps
module np_credit_gate_test;
   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [3:0]       hdr_av = '0, dat_av = '0, tag_av = '0;
   logic [1:0]       valid = '0;
   logic [1:0]       ready;
   logic [1:0][1:0]  hneed;
   logic [1:0][1:0]  tneed;
   logic [1:0][5:0]  len = '0;
   logic [1:0]       grant;
   int               n_cmp = 0;
   int               n_bad = 0;
   bit               done = 1'b0;

   assign hneed = {2'd1, 2'd1};
   assign tneed = {2'd1, 2'd1};

   always #2.5 clk = ~clk;

   np_credit_gate uut (
      .clk(clk), .rst_n(rst_n),
      .hdr_avail_i(hdr_av), .dat_avail_i(dat_av), .tag_avail_i(tag_av),
      .req_valid_i(valid), .req_ready_o(ready),
      .req_hdr_need_i(hneed), .req_tag_need_i(tneed),
      .req_len_i(len), .grant_o(grant)
   );

   typedef struct packed {
      logic [3:0] ah, ad, at;
      logic       v0;
      logic [5:0] l0;
      logic       v1;
      logic [5:0] l1;
      logic [1:0] g;
   } vec_t;

   localparam int NV = 21;
   // every lane needs 1 header credit and 1 tag; data need is ceil(len/4)
   localparam vec_t VT [NV] = '{
      '{4'd7,  4'd3,  4'd5,  1'b1, 6'd1,  1'b0, 6'd0,  2'b01},
      '{4'd7,  4'd3,  4'd5,  1'b1, 6'd0,  1'b1, 6'd0,  2'b11},
      '{4'd7,  4'd3,  4'd5,  1'b1, 6'd4,  1'b1, 6'd4,  2'b11},
      '{4'd6,  4'd2,  4'd4,  1'b1, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd4,  4'd2,  4'd2,  1'b1, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd2,  4'd0,  4'd5,  1'b1, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd0,  4'd4,  4'd5,  1'b1, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd16, 1'b1, 6'd17, 2'b11},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd24, 1'b1, 6'd1,  2'b01},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd0,  1'b1, 6'd1,  2'b01},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd36, 1'b1, 6'd0,  2'b11},
      '{4'd15, 4'd15, 4'd15, 1'b0, 6'd0,  1'b1, 6'd0,  2'b00},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd28, 1'b0, 6'd0,  2'b00},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd28, 1'b0, 6'd0,  2'b01},
      '{4'd1,  4'd1,  4'd1,  1'b1, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd1,  4'd1,  4'd1,  1'b1, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd1,  4'd1,  4'd1,  1'b1, 6'd1,  1'b1, 6'd0,  2'b01},
      '{4'd15, 4'd15, 4'd15, 1'b0, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd15, 4'd15, 4'd15, 1'b0, 6'd0,  1'b0, 6'd0,  2'b00},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd61, 1'b0, 6'd0,  2'b00},
      '{4'd15, 4'd15, 4'd15, 1'b1, 6'd60, 1'b0, 6'd0,  2'b01}
   };

   localparam string TAGS [NV] = '{
      "R5 one-Dword payload", "R6 two no-data lanes", "R3 deduct history",
      "R3 tag exhausted", "R4 two-cycle-old grant", "R2 data count zero",
      "R2 header count zero", "R5 len 16/17 straddled", "R6 lane1 after lane0 drain",
      "R3 saturate to zero", "R6 lane1 zero data", "R6 lane1 alone",
      "R4 still deducted", "R7 held then issued", "R3 header left zero",
      "R4 second cycle", "R6 remaining after lane0", "R4 idle", "R4 idle",
      "R8 need 16 over 15", "R8 need 15 at 15"
   };

   task automatic chk(input string tag, input logic [1:0] act, input logic [1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] ah, ad, at,
                        input logic v0, input logic [5:0] l0,
                        input logic v1, input logic [5:0] l1);
      hdr_av = ah; dat_av = ad; tag_av = at;
      valid  = {v1, v0};
      len    = {l1, l0};
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         finish_run();
      end
   end

   initial begin
      // R1: held in reset with a fitting request
      drive(15, 15, 15, 1'b1, 6'd0, 1'b0, 6'd0);
      @(negedge clk); #1;
      chk("R1 grant in reset", grant, 2'b00);
      chk("R1 ready in reset", ready, 2'b00);
      @(negedge clk);
      rst_n = 1'b1; #1;
      chk("R1 before first edge", grant, 2'b00);
      @(negedge clk); #1;
      chk("R1 after first edge", grant, 2'b01);
      @(negedge clk); drive(15, 15, 15, 1'b0, 6'd0, 1'b0, 6'd0);
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VT[i].ah, VT[i].ad, VT[i].at, VT[i].v0, VT[i].l0, VT[i].v1, VT[i].l1);
         #1;
         chk(TAGS[i], grant, VT[i].g);
      end

      // R7: request needing 5 data credits waits on a count of 3
      @(negedge clk); drive(15, 15, 15, 1'b0, 6'd0, 1'b0, 6'd0);
      @(negedge clk);
      @(negedge clk); drive(3, 3, 3, 1'b1, 6'd20, 1'b0, 6'd0); #1;
      chk("R7 ready low when short", ready, 2'b00);
      chk("R7 not granted when short", grant, 2'b00);
      @(negedge clk); #1;
      chk("R7 still held", grant, 2'b00);
      @(negedge clk); drive(3, 5, 3, 1'b1, 6'd20, 1'b0, 6'd0); #1;
      chk("R7 issued once fits", grant, 2'b01);
      chk("R5 len 20 needs 5", ready[0], 1'b1);

      // R1: reset in mid-run clears history
      @(negedge clk); rst_n = 1'b0; drive(1, 1, 1, 1'b1, 6'd1, 1'b0, 6'd0); #1;
      chk("R1 mid-run reset", grant, 2'b00);
      @(negedge clk); rst_n = 1'b1; #1;
      chk("R1 release not armed", grant, 2'b00);
      @(negedge clk); #1;
      chk("R1 history cleared", grant, 2'b01);
      @(negedge clk); drive(15, 15, 15, 1'b0, 6'd0, 1'b0, 6'd0);
      @(negedge clk);

      done = 1'b1;
      finish_run();
   end
endmodule